// File: doc/BRIEF.md
# Conditional Branch Resolver

This unit settles a relative branch for a small processor core. When the sequencer pulses the evaluate strobe, it presents a condition selector, an invert bit, a mode bit, the four status flags (sign, zero, overflow, carry), a bus of sixteen external condition lines, the program counter value that follows the displacement word, the displacement itself and a direction bit. One clock later the unit reports whether the branch is taken, the resulting program counter and how many microcycles the instruction occupies.

In flag mode the low three bits of the selector pick a flag test, and the invert bit turns each test into its opposite. Selector value 0 is special: with invert clear it is the unconditional branch, and with invert set it is the two-word no-op. Both have fixed timing. In external mode all four selector bits pick one of the sixteen external lines, which is then tested the same way.

A two-state controller drives the result interface. `ST_IDLE` means no fresh result is on the outputs. `ST_REPORT` is the single cycle that follows an evaluate strobe, during which the result-valid flag is high. Transitions: `ST_IDLE` to `ST_REPORT` on a strobe (take), `ST_REPORT` to `ST_REPORT` on a back-to-back strobe (chain), and `ST_REPORT` to `ST_IDLE` when no strobe arrives (retire).

Top module: `bre_branch_eval`

## Requirements
- R1: While reset is low and in the first cycle after it, res_valid_o, taken_o, cycles_o and next_pc_o are all zero.
- R2: res_valid_o is high in exactly the cycle after each cycle with eval_i high. taken_o, cycles_o and next_pc_o change only in that cycle and otherwise hold their values whatever the inputs do.
- R3: In flag mode (ext_mode_i=0, inv_i=0) the raw test for cond_i[2:0] is: 1 carry C, 2 overflow OV, 3 minus S, 4 zero Z, 5 less-than S^OV, 6 less-or-equal Z|(S^OV), 7 sign-differs-from-carry C^S. taken_o equals that test.
- R4: With inv_i=1, selectors 1 to 7 and the external mode take the branch exactly when the raw test is 0 (plus, no-carry, no-overflow, not-equal, greater-or-equal, greater-than, sign-equals-carry).
- R5: In external mode (ext_mode_i=1) the raw test is ext_cond_i[cond_i] over all four selector bits, and the four flags have no effect.
- R6: Flag mode selector 0 with inv_i=0 is always taken with cycles_o=9, whatever the flags.
- R7: Flag mode selector 0 with inv_i=1 is never taken with cycles_o=7, whatever the flags.
- R8: Every other branch reports cycles_o=7 when not taken and 9 when taken.
- R9: When taken, next_pc_o is pc_i+disp_i if dir_i=0 and pc_i-disp_i if dir_i=1, both modulo 2^16. When not taken, next_pc_o is pc_i.
- R10: In flag mode cond_i[3] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Evaluate strobe, one cycle per branch |
| cond_i | input | 4 | Condition selector |
| inv_i | input | 1 | Invert the selected test |
| ext_mode_i | input | 1 | 1 = test an external line, 0 = test flags |
| dir_i | input | 1 | 0 = add displacement, 1 = subtract it |
| flag_s_i | input | 1 | Sign flag |
| flag_z_i | input | 1 | Zero flag |
| flag_ov_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| ext_cond_i | input | 16 | External condition lines |
| pc_i | input | 16 | Address following the displacement word |
| disp_i | input | 16 | Displacement word |
| res_valid_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Branch taken |
| cycles_o | output | 4 | Microcycle count of the instruction |
| next_pc_o | output | 16 | Resulting program counter |

## Verification
On every cycle the assertions check the one-cycle strobe-to-valid relation, that results hold between strobes, that a not-taken result keeps the incoming address and pairs with a 7-cycle count, and the fixed outcome of the unconditional and no-op encodings. Whether each flag combination, inversion and external line gives the right decision, and that address arithmetic wraps correctly in both directions, shows only through the bench's exhaustive scenarios compared against its reference model.

// File: rtl/bre_pkg.sv
package bre_pkg;

    typedef enum logic [2:0] {
        BC_FIXED = 3'd0,
        BC_CARRY = 3'd1,
        BC_OVFL  = 3'd2,
        BC_MINUS = 3'd3,
        BC_ZERO  = 3'd4,
        BC_LESS  = 3'd5,
        BC_LEQ   = 3'd6,
        BC_SGNC  = 3'd7
    } base_cond_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ov;
        logic c;
    } flags_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } state_e;

endpackage

// File: rtl/bre_flag_cond.sv
module bre_flag_cond
    import bre_pkg::*;
(
    input  base_cond_e code_i,
    input  flags_t     flags_i,
    output logic       raw_o,
    output logic       fixed_o
);

    logic signed_lt;

    always_comb begin
        signed_lt = flags_i.s ^ flags_i.ov;
        fixed_o   = 1'b0;
        raw_o     = 1'b0;
        unique case (code_i)
            BC_FIXED: begin
                fixed_o = 1'b1;
                raw_o   = 1'b1;
            end
            BC_CARRY: raw_o = flags_i.c;
            BC_OVFL:  raw_o = flags_i.ov;
            BC_MINUS: raw_o = flags_i.s;
            BC_ZERO:  raw_o = flags_i.z;
            BC_LESS:  raw_o = signed_lt;
            BC_LEQ:   raw_o = flags_i.z | signed_lt;
            BC_SGNC:  raw_o = flags_i.c ^ flags_i.s;
            default:  raw_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bre_ext_sel.sv
module bre_ext_sel #(
    parameter int LINES = 16,
    localparam int SEL_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] lines_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o
);

    logic [LINES-1:0] pick;

    for (genvar g = 0; g < LINES; g++) begin : g_pick
        assign pick[g] = lines_i[g] & (sel_i == SEL_W'(g));
    end

    assign hit_o = |pick;

endmodule

// File: rtl/bre_target_calc.sv
module bre_target_calc #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] disp_i,
    input  logic              back_i,
    output logic [ADDR_W-1:0] target_o
);

    logic [ADDR_W-1:0] operand;

    always_comb begin
        operand  = back_i ? ~disp_i : disp_i;
        target_o = base_i + operand + ADDR_W'(back_i);
    end

endmodule

// File: rtl/bre_branch_eval.sv
module bre_branch_eval
    import bre_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int EXT_N       = 16,
    parameter int BASE_CYC    = 7,
    parameter int TAKEN_EXTRA = 2,
    parameter int UNCOND_CYC  = 9,
    parameter int NOP_CYC     = 7,
    localparam int SEL_W      = $clog2(EXT_N),
    localparam int TAKEN_CYC  = BASE_CYC + TAKEN_EXTRA,
    localparam int MAX_A      = (TAKEN_CYC > UNCOND_CYC) ? TAKEN_CYC : UNCOND_CYC,
    localparam int MAX_CYC    = (MAX_A > NOP_CYC) ? MAX_A : NOP_CYC,
    localparam int CYC_W      = $clog2(MAX_CYC + 1)
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              eval_i,
    input  logic [SEL_W-1:0]  cond_i,
    input  logic              inv_i,
    input  logic              ext_mode_i,
    input  logic              dir_i,
    input  logic              flag_s_i,
    input  logic              flag_z_i,
    input  logic              flag_ov_i,
    input  logic              flag_c_i,
    input  logic [EXT_N-1:0]  ext_cond_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] disp_i,
    output logic              res_valid_o,
    output logic              taken_o,
    output logic [CYC_W-1:0]  cycles_o,
    output logic [ADDR_W-1:0] next_pc_o
);

    localparam logic [CYC_W-1:0] C_BASE   = CYC_W'(BASE_CYC);
    localparam logic [CYC_W-1:0] C_TAKEN  = CYC_W'(TAKEN_CYC);
    localparam logic [CYC_W-1:0] C_UNCOND = CYC_W'(UNCOND_CYC);
    localparam logic [CYC_W-1:0] C_NOP    = CYC_W'(NOP_CYC);

    state_e state_q, state_d;

    flags_t     flags;
    base_cond_e base_code;
    logic       flag_raw, flag_fixed, ext_hit;
    logic       raw_test, fixed_kind;
    logic       taken_d;
    logic [CYC_W-1:0]  cycles_d;
    logic [ADDR_W-1:0] target, next_pc_d;

    assign flags     = '{s: flag_s_i, z: flag_z_i, ov: flag_ov_i, c: flag_c_i};
    assign base_code = base_cond_e'(cond_i[2:0]);

    bre_flag_cond u_flag (
        .code_i  (base_code),
        .flags_i (flags),
        .raw_o   (flag_raw),
        .fixed_o (flag_fixed)
    );

    bre_ext_sel #(.LINES(EXT_N)) u_ext (
        .lines_i (ext_cond_i),
        .sel_i   (cond_i),
        .hit_o   (ext_hit)
    );

    bre_target_calc #(.ADDR_W(ADDR_W)) u_tgt (
        .base_i   (pc_i),
        .disp_i   (disp_i),
        .back_i   (dir_i),
        .target_o (target)
    );

    // Decision and timing for the instruction presented this cycle
    always_comb begin
        raw_test   = ext_mode_i ? ext_hit : flag_raw;
        fixed_kind = !ext_mode_i && flag_fixed;
        if (fixed_kind) begin
            taken_d  = !inv_i;
            cycles_d = inv_i ? C_NOP : C_UNCOND;
        end else begin
            taken_d  = raw_test ^ inv_i;
            cycles_d = taken_d ? C_TAKEN : C_BASE;
        end
        next_pc_d = taken_d ? target : pc_i;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = eval_i ? ST_REPORT : ST_IDLE;   // take
            ST_REPORT: state_d = eval_i ? ST_REPORT : ST_IDLE;   // chain / retire
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    // Result registers
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            taken_o   <= 1'b0;
            cycles_o  <= '0;
            next_pc_o <= '0;
        end else if (eval_i) begin
            taken_o   <= taken_d;
            cycles_o  <= cycles_d;
            next_pc_o <= next_pc_d;
        end
    end

    assign res_valid_o = (state_q == ST_REPORT);

    AST_VALID_AFTER_EVAL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        eval_i |=> res_valid_o); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !eval_i |=> !res_valid_o); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !eval_i |=> ($stable(taken_o) && $stable(cycles_o) && $stable(next_pc_o))); // R2
    AST_NOT_TAKEN_PC: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        eval_i && !taken_d |=> (next_pc_o == $past(pc_i))); // R9
    AST_UNCOND_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        eval_i && !ext_mode_i && cond_i[2:0] == 3'd0 && !inv_i |=> taken_o && cycles_o == C_UNCOND); // R6
    AST_NOP_SKIPPED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        eval_i && !ext_mode_i && cond_i[2:0] == 3'd0 && inv_i |=> !taken_o && cycles_o == C_NOP); // R7
    AST_NOT_TAKEN_CYC: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        res_valid_o && !taken_o |-> (cycles_o == C_BASE || cycles_o == C_NOP)); // R8

endmodule

// File: tb/bre_branch_eval_tb_top.sv
module bre_branch_eval_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval = 1'b0;
    logic [3:0]  cond = '0;
    logic        inv = 1'b0, ext_mode = 1'b0, dir = 1'b0;
    logic        fs = 1'b0, fz = 1'b0, fov = 1'b0, fc = 1'b0;
    logic [15:0] ext = '0, pc = '0, disp = '0;
    logic        res_valid, taken;
    logic [3:0]  cycles;
    logic [15:0] next_pc;

    int    checks = 0, errors = 0, cyc_cnt = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    int m_valid = 0, m_taken = 0, m_cyc = 0, m_pc = 0;

    always #10 clk = ~clk;

    bre_branch_eval dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .eval_i(eval), .cond_i(cond), .inv_i(inv),
        .ext_mode_i(ext_mode), .dir_i(dir), .flag_s_i(fs), .flag_z_i(fz),
        .flag_ov_i(fov), .flag_c_i(fc), .ext_cond_i(ext), .pc_i(pc), .disp_i(disp),
        .res_valid_o(res_valid), .taken_o(taken), .cycles_o(cycles), .next_pc_o(next_pc)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ref_taken();
        int sel = cond % 8;
        int t;
        if (ext_mode) return (ext[cond] ^ inv) ? 1 : 0;
        if (sel == 0) return inv ? 0 : 1;
        if      (sel == 1) t = fc;
        else if (sel == 2) t = fov;
        else if (sel == 3) t = fs;
        else if (sel == 4) t = fz;
        else if (sel == 5) t = (fs != fov);
        else if (sel == 6) t = fz || (fs != fov);
        else               t = (fc != fs);
        return inv ? 1 - t : t;
    endfunction

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0; m_taken = 0; m_cyc = 0; m_pc = 0;
        end else begin
            m_valid = eval;
            if (eval) begin
                m_taken = ref_taken();
                if (!ext_mode && cond % 8 == 0) m_cyc = inv ? 7 : 9;
                else                            m_cyc = m_taken ? 9 : 7;
                if (m_taken) m_pc = dir ? (int'(pc) - int'(disp)) & 16'hFFFF
                                        : (int'(pc) + int'(disp)) & 16'hFFFF;
                else         m_pc = pc;
            end
        end
    end

    // comparison on every clock, away from the active edge
    always @(negedge clk) begin
        cyc_cnt++;
        if (cmp_on) begin
            chk("R2 valid", res_valid, m_valid);
            chk({cur_req, " taken"}, taken, m_taken);
            chk({cur_req, " cycles"}, cycles, m_cyc);
            chk({cur_req, " next_pc"}, next_pc, m_pc);
        end
    end

    task automatic strobe(int c, bit iv, bit em, bit d, bit [3:0] fl,
                          bit [15:0] e, bit [15:0] p, bit [15:0] dp);
        cond = 4'(c); inv = iv; ext_mode = em; dir = d;
        {fs, fz, fov, fc} = fl; ext = e; pc = p; disp = dp;
        eval = 1'b1;
        @(negedge clk);
        eval = 1'b0;
    endtask

    task automatic idle_scramble(int n);
        for (int i = 0; i < n; i++) begin
            cond = 4'($urandom); inv = 1'($urandom); ext_mode = 1'($urandom);
            {fs, fz, fov, fc} = 4'($urandom); ext = 16'($urandom);
            pc = 16'($urandom); disp = 16'($urandom); dir = 1'($urandom);
            @(negedge clk);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        chk("R1 valid", res_valid, 0); chk("R1 taken", taken, 0);
        chk("R1 cycles", cycles, 0);   chk("R1 next_pc", next_pc, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-reset cycles", cycles, 0);
        cmp_on = 1'b1;

        // R3/R4/R6/R7/R8: all flag-mode selectors, both senses, all flags
        for (int c = 0; c < 8; c++) begin
            for (int iv = 0; iv < 2; iv++) begin
                if (c == 0) cur_req = iv ? "R7" : "R6";
                else        cur_req = iv ? "R4" : "R3";
                for (int f = 0; f < 16; f++)
                    strobe(c, iv[0], 1'b0, f[0], 4'(f), 16'($urandom),
                           16'h1000 + 16'(f), 16'h0040);
            end
        end
        cur_req = "R8";
        strobe(1, 0, 0, 0, 4'b0001, 16'h0, 16'h0200, 16'h0010); // carry set: 9 cycles
        strobe(1, 0, 0, 0, 4'b0000, 16'h0, 16'h0200, 16'h0010); // carry clear: 7 cycles

        // R2: hold while inputs move without a strobe
        cur_req = "R2";
        idle_scramble(6);

        // R5: external mode, every line, one-hot and inverse patterns, flags toggled
        cur_req = "R5";
        for (int s = 0; s < 16; s++) begin
            strobe(s, 0, 1'b1, 0, 4'($urandom), 16'(1 << s), 16'h3000, 16'h0004);
            strobe(s, 0, 1'b1, 0, 4'($urandom), ~16'(1 << s), 16'h3000, 16'h0004);
            strobe(s, 1, 1'b1, 1, 4'hF, 16'(1 << s), 16'h3000, 16'h0004);
            strobe(s, 1, 1'b1, 1, 4'h0, ~16'(1 << s), 16'h3000, 16'h0004);
        end

        // R10: upper selector bit in flag mode
        cur_req = "R10";
        for (int c = 8; c < 16; c++)
            for (int f = 0; f < 16; f += 5)
                strobe(c, 1'(c), 1'b0, 0, 4'(f), 16'hFFFF, 16'h0400, 16'h0008);

        // R9: wraparound in both directions, and not-taken keeps pc
        cur_req = "R9";
        strobe(0, 0, 0, 0, 4'h0, 16'h0, 16'hFFF0, 16'h0020); // -> 0010
        strobe(0, 0, 0, 1, 4'h0, 16'h0, 16'h0005, 16'h0010); // -> FFF5
        strobe(0, 1, 0, 1, 4'h0, 16'h0, 16'h1234, 16'h0100); // not taken -> 1234
        strobe(0, 0, 0, 1, 4'h0, 16'h0, 16'h8000, 16'h8000); // -> 0000
        @(negedge clk);
        chk("R9 explicit wrap", next_pc, 16'h0000);

        cur_req = "R2";
        idle_scramble(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc_cnt > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc_cnt);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule